// File: doc/BRIEF.md
# Chip-wide Pedestal Estimator and Subtractor

This block removes a common baseline offset from the parsed sample stream of one front-end chip. The chip delivers its channels as frames of 128 samples, and one pedestal value applies to every channel of the chip. Each valid sample has the active pedestal subtracted from it. The result is clamped at zero, so it never wraps. When subtraction is disabled, samples pass through unchanged. The data path takes one sample per clock and has a fixed two-cycle latency.

The pedestal comes from one of two sources. In automatic mode it is measured from the stream itself: a start pulse arms a measurement. The measurement averages the 1024 valid samples of the eight frames that follow the next frame start. In manual mode the value on a dedicated input port is used. Whichever source is selected, the active pedestal is loaded only on the first sample of a frame. One frame is therefore never corrected with two different values.

Top module: `ped_corrector`

## Requirements
- R1: While reset is asserted and after its release, `valid_o`, `ped_o` and `busy_o` are all zero until stimulus arrives.
- R2: Each cycle with `valid_i` high produces exactly one cycle with `valid_o` high two clock edges later, in input order. Cycles with `valid_i` low produce no output.
- R3: With `sub_en_i` high for a sample, `data_o` is the sample minus the active pedestal, or zero when the pedestal exceeds the sample.
- R4: With `sub_en_i` low for a sample, `data_o` equals the sample unchanged.
- R5: With `mode_i` = 1 (manual), the active pedestal is loaded from `manual_ped_i` on the first sample of each frame. Changes of `manual_ped_i` inside a frame have no effect until the next frame.
- R6: Valid samples are counted modulo 128 from reset. Index 0 is the first sample of a frame.
- R7: A start pulse while idle raises `busy_o` in the next cycle. Measurement begins at the next frame start after the pulse and covers exactly 1024 valid samples. The stored result is the floor of their sum divided by 1024. `busy_o` falls in the cycle after the 1024th sample.
- R8: A start pulse while `busy_o` is high is ignored. The running measurement neither restarts nor extends.
- R9: With `mode_i` = 0 (automatic), the active pedestal is loaded from the last measured result on the first sample of each frame, and `ped_o` changes at no other time. Before any measurement completes, the measured result is zero.
- R10: Cycles with `valid_i` low advance neither the frame index nor the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| data_i | input | DATA_W | Parsed channel sample |
| start_i | input | 1 | One-cycle pulse arming a pedestal measurement |
| mode_i | input | 1 | Pedestal source: 1 manual, 0 measured |
| manual_ped_i | input | DATA_W | Manually supplied pedestal |
| sub_en_i | input | 1 | Subtraction enable, sampled with each sample |
| valid_o | output | 1 | Output sample qualifier |
| data_o | output | DATA_W | Corrected sample |
| ped_o | output | DATA_W | Active pedestal |
| busy_o | output | 1 | Measurement armed or in progress |

## Verification
The bench feeds samples below, equal to and above the pedestal. A design that wrapped instead of clamping would show large values where zero is expected. A manual value is changed in the middle of a frame, and a start pulse is given mid-frame. A design that updated the pedestal at once, or that began averaging before the frame start, would correct part of a frame with the wrong value or report a skewed mean. The bench repeats a start pulse during a measurement and checks that `busy_o` drops exactly after the 1024th sample. Idle cycles are scattered through the frames, so any design that counted invalid cycles loses frame alignment.

// File: rtl/ped_pkg.sv
package ped_pkg;
  typedef enum logic [1:0] {
    MEAS_IDLE  = 2'd0,
    MEAS_ARMED = 2'd1,
    MEAS_ACC   = 2'd2
  } meas_state_e;

  localparam int unsigned DEF_DATA_W     = 12;
  localparam int unsigned DEF_CHANNELS   = 128;
  localparam int unsigned DEF_AVG_FRAMES = 8;
endpackage

// File: rtl/ped_frame_tracker.sv
module ped_frame_tracker #(
  parameter int unsigned CHANNELS = ped_pkg::DEF_CHANNELS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic frame_first_o
);
  localparam int unsigned CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(CHANNELS - 1);

  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
    end else if (valid_i) begin
      chan_q <= (chan_q == LAST_CH) ? '0 : chan_q + 1'b1;
    end
  end

  assign frame_first_o = valid_i && (chan_q == '0);
endmodule

// File: rtl/ped_meter.sv
module ped_meter
  import ped_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned CHANNELS   = DEF_CHANNELS,
  parameter int unsigned AVG_FRAMES = DEF_AVG_FRAMES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              frame_first_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] meas_o
);
  localparam int unsigned NSAMP = CHANNELS * AVG_FRAMES;
  localparam int unsigned LOG2N = $clog2(NSAMP);
  localparam int unsigned CNT_W = (LOG2N > 0) ? LOG2N : 1;
  localparam int unsigned SUM_W = DATA_W + LOG2N;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NSAMP - 1);

  meas_state_e      state_q, state_d;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] meas_q, meas_d;
  logic [SUM_W-1:0] sum_next;

  assign sum_next = sum_q + SUM_W'(data_i);

  always_comb begin
    state_d = state_q;
    sum_d   = sum_q;
    cnt_d   = cnt_q;
    meas_d  = meas_q;
    unique case (state_q)
      MEAS_IDLE: begin
        if (start_i) state_d = MEAS_ARMED;
      end
      MEAS_ARMED: begin
        if (frame_first_i) begin
          state_d = MEAS_ACC;
          sum_d   = SUM_W'(data_i);
          cnt_d   = CNT_W'(1);
        end
      end
      MEAS_ACC: begin
        if (valid_i) begin
          if (cnt_q == LAST_CNT) begin
            meas_d  = sum_next[SUM_W-1 -: DATA_W];
            state_d = MEAS_IDLE;
            cnt_d   = '0;
          end else begin
            sum_d = sum_next;
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = MEAS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MEAS_IDLE;
      sum_q   <= '0;
      cnt_q   <= '0;
      meas_q  <= '0;
    end else begin
      state_q <= state_d;
      sum_q   <= sum_d;
      cnt_q   <= cnt_d;
      meas_q  <= meas_d;
    end
  end

  assign busy_o = (state_q != MEAS_IDLE);
  assign meas_o = meas_q;
endmodule

// File: rtl/ped_subtract.sv
module ped_subtract #(
  parameter int unsigned DATA_W = ped_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] ped_i,
  input  logic              en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              s1_valid_q;
  logic [DATA_W-1:0] s1_data_q, s1_ped_q;
  logic              s1_en_q;
  logic [DATA_W:0]   diff;
  logic [DATA_W-1:0] res;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_data_q  <= '0;
      s1_ped_q   <= '0;
      s1_en_q    <= 1'b0;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) begin
        s1_data_q <= data_i;
        s1_ped_q  <= ped_i;
        s1_en_q   <= en_i;
      end
    end
  end

  // borrow bit flags pedestal above sample: clamp to zero
  assign diff = {1'b0, s1_data_q} - {1'b0, s1_ped_q};
  assign res  = !s1_en_q ? s1_data_q : (diff[DATA_W] ? '0 : diff[DATA_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= s1_valid_q;
      if (s1_valid_q) data_q <= res;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/ped_corrector.sv
module ped_corrector
  import ped_pkg::*;
#(
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned CHANNELS   = DEF_CHANNELS,
  parameter int unsigned AVG_FRAMES = DEF_AVG_FRAMES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] manual_ped_i,
  input  logic              sub_en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] ped_o,
  output logic              busy_o
);
  logic              frame_first;
  logic [DATA_W-1:0] meas;
  logic [DATA_W-1:0] act_ped_q;
  logic [DATA_W-1:0] src_ped;
  logic [DATA_W-1:0] use_ped;

  ped_frame_tracker #(.CHANNELS(CHANNELS)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .frame_first_o(frame_first)
  );

  ped_meter #(
    .DATA_W    (DATA_W),
    .CHANNELS  (CHANNELS),
    .AVG_FRAMES(AVG_FRAMES)
  ) u_meter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .valid_i      (valid_i),
    .data_i       (data_i),
    .frame_first_i(frame_first),
    .busy_o       (busy_o),
    .meas_o       (meas)
  );

  assign src_ped = mode_i ? manual_ped_i : meas;
  // first sample of a frame already uses the freshly loaded value
  assign use_ped = frame_first ? src_ped : act_ped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_ped_q <= '0;
    else if (frame_first) act_ped_q <= src_ped;
  end

  ped_subtract #(.DATA_W(DATA_W)) u_sub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .ped_i  (use_ped),
    .en_i   (sub_en_i),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  assign ped_o = act_ped_q;
endmodule

// File: rtl/ped_corrector_chk.sv
module ped_corrector_chk #(
  parameter int unsigned DATA_W = ped_pkg::DEF_DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              start_i,
  input logic              sub_en_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic [DATA_W-1:0] ped_o,
  input logic              busy_o,
  input logic              frame_first_i
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (valid_o == $past(valid_i, 2))) else $error("latency"); // R2

  AST_SAT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && valid_o && $past(sub_en_i, 2)) |-> (data_o <= $past(data_i, 2)))
    else $error("subtract above input"); // R3

  AST_BYPASS_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && valid_o && !$past(sub_en_i, 2)) |-> (data_o == $past(data_i, 2)))
    else $error("bypass altered data"); // R4

  AST_PED_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !$past(frame_first_i)) |-> $stable(ped_o))
    else $error("pedestal changed mid-frame"); // R9

  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && $rose(busy_o)) |-> $past(start_i))
    else $error("busy without start"); // R7
endmodule

bind ped_corrector ped_corrector_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .data_i       (data_i),
  .start_i      (start_i),
  .sub_en_i     (sub_en_i),
  .valid_o      (valid_o),
  .data_o       (data_o),
  .ped_o        (ped_o),
  .busy_o       (busy_o),
  .frame_first_i(frame_first)
);

// File: tb/tb_ped_corrector.sv
`timescale 1ns/1ps
module tb_ped_corrector;
  localparam int DW = 12;
  localparam int CH = 128;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [DW-1:0] manual_ped_i = '0;
  logic          sub_en_i = 1'b0;
  logic          valid_o;
  logic [DW-1:0] data_o;
  logic [DW-1:0] ped_o;
  logic          busy_o;

  always #10 clk = ~clk;

  ped_corrector dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .start_i(start_i), .mode_i(mode_i), .manual_ped_i(manual_ped_i),
    .sub_en_i(sub_en_i), .valid_o(valid_o), .data_o(data_o),
    .ped_o(ped_o), .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  int b_chan = 0;
  logic [DW-1:0] b_act = '0;
  logic [DW-1:0] b_meas = '0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: one sample per call, scoreboard item pushed
  task automatic send(input int d, input bit en);
    logic [DW-1:0] e;
    @(negedge clk);
    if (b_chan == 0) b_act = mode_i ? manual_ped_i : b_meas;  // R6 frame start
    if (!en) e = DW'(d);                                     // R4
    else e = (DW'(d) > b_act) ? DW'(d) - b_act : '0;          // R3
    exp_q.push_back(e);
    valid_i  = 1'b1;
    data_i   = DW'(d);
    sub_en_i = en;
    @(posedge clk);
    #1;
    valid_i = 1'b0;
    if (mode_i) check(ped_o == b_act, "R5 pedestal", int'(ped_o), int'(b_act));
    else        check(ped_o == b_act, "R9 pedestal", int'(ped_o), int'(b_act));
    b_chan = (b_chan + 1) % CH;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    #1;
    start_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected output", int'(data_o), -1);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(data_o == e, "R2/R3/R4 data", int'(data_o), int'(e));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
    check(ped_o == '0, "R1 ped", int'(ped_o), 0);
    check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    #1;
    check(valid_o == 1'b0 && busy_o == 1'b0, "R1 after release", int'(valid_o), 0);

    // frame 0: auto mode, nothing measured, bypass then enabled with zero pedestal
    mode_i = 1'b0;
    for (int i = 0; i < CH; i++) send((i * 37) % 4096, i[0]);

    // manual frames, with idle gaps (R10) and saturation (R3)
    mode_i = 1'b1;
    manual_ped_i = 12'd100;
    for (int i = 0; i < CH; i++) begin
      if (i == 60) manual_ped_i = 12'd200;   // R5 mid-frame change ignored
      send(90 + i, 1'b1);
      if (i % 17 == 3) idle(2);
    end
    for (int i = 0; i < CH; i++) begin
      send((i == 5) ? 200 : 4095 - i, i != 7);
      if (i % 29 == 1) idle(1);
    end

    // auto measurement: start mid-frame
    mode_i = 1'b0;
    for (int i = 0; i < 40; i++) send(50, 1'b1);
    pulse_start();
    check(busy_o == 1'b1, "R7 busy rise", int'(busy_o), 1);
    for (int i = 40; i < CH; i++) send(50, 1'b1);  // not part of the average
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < CH; i++) begin
        send(300 + (i % 8), 1'b1);
        if (i == 64 && f == 3) begin
          pulse_start();                             // R8 ignored
          check(busy_o == 1'b1, "R8 still busy", int'(busy_o), 1);
        end
        if (i % 50 == 9) idle(1);
      end
      if (f < 7) check(busy_o == 1'b1, "R7 busy during", int'(busy_o), 1);
    end
    check(busy_o == 1'b0, "R7/R8 busy falls after 1024", int'(busy_o), 0);
    check(ped_o == '0, "R9 no mid-stream update", int'(ped_o), 0);
    b_meas = 12'd303;                                // floor(303.5)
    for (int i = 0; i < CH; i++) send((i < 3) ? 200 : 400, 1'b1);
    check(ped_o == 12'd303, "R7 measured mean", int'(ped_o), 303);

    idle(4);
    check(exp_q.size() == 0, "R2 all outputs seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule